// File: doc/BRIEF.md
# Scoreboard Register Dependency Matrix

This block is the register-facing half of a scoreboard. It is a grid of dependency cells with one row per Function Unit and one column per architectural register. The candidate instruction presents its destination register and its two source registers, each as a one-hot vector. Bit r of each vector stands for register r. Bit f of each per-unit vector (issue, go-read, go-write, hazard outputs) stands for Function Unit f. When the issue bit of a unit is high, every cell in that unit's row whose register is named as destination or source stores a reservation in a flip-flop.

The reservations serve two purposes. The first is hazard detection. For each unit row the block reports a read-after-write flag and a write-after-read flag. Each flag is formed against the operand vectors currently presented, across all registers and across every other unit's row, so the issue logic can decide whether an instruction may go to that unit. The second is register-file selection. When the external priority picker grants go-read or go-write to a unit, that unit's reserved columns drive one select bit per register. All rows of a column are ORed together, and the reservation that produced the select is dropped at the end of the grant cycle.

Everything is on one clock with a synchronous active-high reset.

Top module: `sb_dep_matrix`

## Requirements
- R1: While reset is high, every reservation is cleared. After reset, with no issue, all hazard flags and all select bits are zero for any operand vectors and any grants.
- R2: When issue_i[f] is high at a clock edge, unit f gains a destination reservation on each register whose dest_i bit is high, and a source reservation on each register whose src1_i or src2_i bit is high. The reservations take effect from the next cycle.
- R3: raw_o[f] is high in a cycle when some unit g other than f holds a destination reservation on a register whose bit is set in src1_i or src2_i.
- R4: war_o[f] is high in a cycle when some unit g other than f holds a source reservation on a register whose bit is set in dest_i.
- R5: rd_sel_o[r] is high in a cycle where a unit with go_rd_i set holds a source reservation on register r. wr_sel_o[r] is high in a cycle where a unit with go_wr_i set holds a destination reservation on register r. Both are zero when no grant is present.
- R6: A select bit of one register column is the OR over all unit rows of that column. A reservation still held by another unit drives the bit when that unit is granted later.
- R7: At the edge ending a cycle with go_rd_i[f] high, all of unit f's source reservations are released. At the edge ending a cycle with go_wr_i[f] high, all of its destination reservations are released. So a grant held for two cycles yields a select for one cycle only, and the released register no longer raises hazards.
- R8: When issue and a grant reach the same reservation in the same cycle, the new reservation is kept.
- R9: A unit's own reservations never contribute to its own raw_o or war_o bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | NUM_FU | Issue strobe per unit, bit f = unit f |
| dest_i | input | NUM_REG | One-hot destination register of the candidate instruction |
| src1_i | input | NUM_REG | One-hot first source register |
| src2_i | input | NUM_REG | One-hot second source register |
| go_rd_i | input | NUM_FU | Read grant per unit |
| go_wr_i | input | NUM_FU | Write grant per unit |
| raw_o | output | NUM_FU | Read-after-write hazard per unit row |
| war_o | output | NUM_FU | Write-after-read hazard per unit row |
| rd_sel_o | output | NUM_REG | Register-file read select per register |
| wr_sel_o | output | NUM_REG | Register-file write select per register |

## Verification
Issue and release can land in the same cycle on the same unit, where a new reservation and the grant's clear meet in one flip-flop. The bench provokes this by issuing a unit while it already holds a reservation and is granted in that same cycle. The kept reservation must then appear as a select under a repeated grant in the following cycle, and the old one must be gone. The check is made against a cycle-level reference matrix in the bench.

// File: rtl/sb_dep_pkg.sv
package sb_dep_pkg;

  // Outputs of one dependency cell.
  typedef struct packed {
    logic dest_q;   // destination reservation held
    logic src_q;    // any source reservation held
    logic raw_p;    // this cell sees a read of its reserved destination
    logic war_p;    // this cell sees a write to its reserved source
    logic rd_sel;   // read select contribution
    logic wr_sel;   // write select contribution
  } cell_out_t;

  // Next state of a reservation flop: a new set is stronger than a clear.
  function automatic logic next_resv(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

endpackage

// File: rtl/sb_dep_cell.sv
module sb_dep_cell
  import sb_dep_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      issue,
  input  logic      dest_b,
  input  logic      src1_b,
  input  logic      src2_b,
  input  logic      go_rd,
  input  logic      go_wr,
  output cell_out_t cell_o
);

  logic d_q, s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      d_q  <= 1'b0;
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      d_q  <= next_resv(d_q,  issue & dest_b, go_wr);
      s1_q <= next_resv(s1_q, issue & src1_b, go_rd);
      s2_q <= next_resv(s2_q, issue & src2_b, go_rd);
    end
  end

  always_comb begin
    cell_o.dest_q = d_q;
    cell_o.src_q  = s1_q | s2_q;
    cell_o.raw_p  = d_q & (src1_b | src2_b);
    cell_o.war_p  = (s1_q | s2_q) & dest_b;
    cell_o.rd_sel = go_rd & (s1_q | s2_q);
    cell_o.wr_sel = go_wr & d_q;
  end

endmodule

// File: rtl/sb_col_merge.sv
module sb_col_merge #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int CELLS  = NUM_FU * NUM_REG
) (
  input  logic [CELLS-1:0]   cell_sel,
  output logic [NUM_REG-1:0] col_sel
);

  // cell index = fu*NUM_REG + reg
  for (genvar r = 0; r < NUM_REG; r++) begin : g_col
    logic [NUM_FU-1:0] column;
    for (genvar f = 0; f < NUM_FU; f++) begin : g_row
      assign column[f] = cell_sel[f*NUM_REG + r];
    end
    assign col_sel[r] = |column;
  end

endmodule

// File: rtl/sb_hazard_merge.sv
module sb_hazard_merge #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int CELLS  = NUM_FU * NUM_REG
) (
  input  logic [CELLS-1:0]  cell_hit,
  output logic [NUM_FU-1:0] row_flag
);

  // Per-row OR over registers, then OR of all rows except the own one.
  logic [NUM_FU-1:0] row_any;

  for (genvar f = 0; f < NUM_FU; f++) begin : g_any
    assign row_any[f] = |cell_hit[f*NUM_REG +: NUM_REG];
  end

  for (genvar f = 0; f < NUM_FU; f++) begin : g_flag
    localparam logic [NUM_FU-1:0] OWN = NUM_FU'(1) << f;
    assign row_flag[f] = |(row_any & ~OWN);
  end

endmodule

// File: rtl/sb_dep_matrix.sv
module sb_dep_matrix
  import sb_dep_pkg::*;
#(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_FU-1:0]  issue_i,
  input  logic [NUM_REG-1:0] dest_i,
  input  logic [NUM_REG-1:0] src1_i,
  input  logic [NUM_REG-1:0] src2_i,
  input  logic [NUM_FU-1:0]  go_rd_i,
  input  logic [NUM_FU-1:0]  go_wr_i,
  output logic [NUM_FU-1:0]  raw_o,
  output logic [NUM_FU-1:0]  war_o,
  output logic [NUM_REG-1:0] rd_sel_o,
  output logic [NUM_REG-1:0] wr_sel_o
);

  localparam int CELLS = NUM_FU * NUM_REG;

  // Named cell-level events, index fu*NUM_REG + reg.
  logic [CELLS-1:0] dest_q_m, src_q_m;
  logic [CELLS-1:0] raw_p_m, war_p_m;
  logic [CELLS-1:0] rd_p_m, wr_p_m;

  for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
      localparam int IDX = f*NUM_REG + r;
      cell_out_t co;
      sb_dep_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .issue  (issue_i[f]),
        .dest_b (dest_i[r]),
        .src1_b (src1_i[r]),
        .src2_b (src2_i[r]),
        .go_rd  (go_rd_i[f]),
        .go_wr  (go_wr_i[f]),
        .cell_o (co)
      );
      assign dest_q_m[IDX] = co.dest_q;
      assign src_q_m[IDX]  = co.src_q;
      assign raw_p_m[IDX]  = co.raw_p;
      assign war_p_m[IDX]  = co.war_p;
      assign rd_p_m[IDX]   = co.rd_sel;
      assign wr_p_m[IDX]   = co.wr_sel;
    end
  end

  sb_col_merge #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_rd_merge (
    .cell_sel (rd_p_m),
    .col_sel  (rd_sel_o)
  );

  sb_col_merge #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_wr_merge (
    .cell_sel (wr_p_m),
    .col_sel  (wr_sel_o)
  );

  sb_hazard_merge #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_raw_merge (
    .cell_hit (raw_p_m),
    .row_flag (raw_o)
  );

  sb_hazard_merge #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_war_merge (
    .cell_hit (war_p_m),
    .row_flag (war_o)
  );

endmodule

// File: rtl/sb_dep_matrix_chk.sv
module sb_dep_matrix_chk #(
  parameter int NUM_FU  = 4,
  parameter int NUM_REG = 8,
  localparam int CELLS  = NUM_FU * NUM_REG
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_FU-1:0]  issue_i,
  input logic [NUM_REG-1:0] dest_i,
  input logic [NUM_FU-1:0]  go_rd_i,
  input logic [NUM_FU-1:0]  go_wr_i,
  input logic [NUM_FU-1:0]  raw_o,
  input logic [NUM_REG-1:0] rd_sel_o,
  input logic [NUM_REG-1:0] wr_sel_o,
  input logic [CELLS-1:0]   dest_q_m,
  input logic [CELLS-1:0]   src_q_m
);

  // R5: no grant, no select
  a_r5_rd_idle: assert property (@(posedge clk) disable iff (rst)
    (go_rd_i == '0) |-> (rd_sel_o == '0));
  a_r5_wr_idle: assert property (@(posedge clk) disable iff (rst)
    (go_wr_i == '0) |-> (wr_sel_o == '0));

  for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
    localparam logic [CELLS-1:0] ROW = {{(CELLS-NUM_REG){1'b0}}, {NUM_REG{1'b1}}} << (f*NUM_REG);
    logic others_dest;
    assign others_dest = |(dest_q_m & ~ROW);

    // R2: issue leaves the destination reserved in the next cycle
    a_r2_issue_sets: assert property (@(posedge clk) disable iff (rst)
      issue_i[f] |=> ((dest_q_m[f*NUM_REG +: NUM_REG] & $past(dest_i)) == $past(dest_i)));

    // R7: a grant without a new issue empties the row's reservations
    a_r7_rd_release: assert property (@(posedge clk) disable iff (rst)
      (go_rd_i[f] && !issue_i[f]) |=> (src_q_m[f*NUM_REG +: NUM_REG] == '0));
    a_r7_wr_release: assert property (@(posedge clk) disable iff (rst)
      (go_wr_i[f] && !issue_i[f]) |=> (dest_q_m[f*NUM_REG +: NUM_REG] == '0));

    // R9: with no destination held elsewhere, no read-after-write for this row
    a_r9_raw_own_excluded: assert property (@(posedge clk) disable iff (rst)
      !others_dest |-> !raw_o[f]);
  end

endmodule

bind sb_dep_matrix sb_dep_matrix_chk #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .issue_i  (issue_i),
  .dest_i   (dest_i),
  .go_rd_i  (go_rd_i),
  .go_wr_i  (go_wr_i),
  .raw_o    (raw_o),
  .rd_sel_o (rd_sel_o),
  .wr_sel_o (wr_sel_o),
  .dest_q_m (dest_q_m),
  .src_q_m  (src_q_m)
);

// File: tb/sb_dep_matrix_bench.sv
module sb_dep_matrix_bench;

  localparam int NF = 4;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NF-1:0] issue_i = '0, go_rd_i = '0, go_wr_i = '0;
  logic [NR-1:0] dest_i = '0, src1_i = '0, src2_i = '0;
  logic [NF-1:0] raw_o, war_o;
  logic [NR-1:0] rd_sel_o, wr_sel_o;

  int checks = 0;
  int fails  = 0;

  // Reference matrix: per unit, reserved registers.
  logic [NR-1:0] m_dst [NF];
  logic [NR-1:0] m_src [NF];

  sb_dep_matrix #(.NUM_FU(NF), .NUM_REG(NR)) u_sb_dep_matrix (
    .clk, .rst, .issue_i, .dest_i, .src1_i, .src2_i,
    .go_rd_i, .go_wr_i, .raw_o, .war_o, .rd_sel_o, .wr_sel_o
  );

  always #4 clk = ~clk;  // 125 MHz

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int f = 0; f < NF; f++) begin
      m_dst[f] = '0;
      m_src[f] = '0;
    end
  endtask

  // One cycle: drive at falling edge, compare outputs against the model,
  // then advance the model at the rising edge.
  task automatic cyc(input logic [NF-1:0] iss, input logic [NR-1:0] d,
                     input logic [NR-1:0] s1, input logic [NR-1:0] s2,
                     input logic [NF-1:0] gr, input logic [NF-1:0] gw);
    logic [NF-1:0] e_raw, e_war;
    logic [NR-1:0] e_rd, e_wr;
    @(negedge clk);
    issue_i = iss; dest_i = d; src1_i = s1; src2_i = s2; go_rd_i = gr; go_wr_i = gw;
    e_raw = '0; e_war = '0; e_rd = '0; e_wr = '0;
    for (int f = 0; f < NF; f++) begin
      for (int g = 0; g < NF; g++) begin
        if (g != f) begin
          if ((m_dst[g] & (s1 | s2)) != '0) e_raw[f] = 1'b1;
          if ((m_src[g] & d) != '0)         e_war[f] = 1'b1;
        end
      end
      if (gr[f]) e_rd = e_rd | m_src[f];
      if (gw[f]) e_wr = e_wr | m_dst[f];
    end
    #1;
    chk("R3 raw_o", 32'(raw_o), 32'(e_raw));
    chk("R4 war_o", 32'(war_o), 32'(e_war));
    chk("R5 rd_sel_o", 32'(rd_sel_o), 32'(e_rd));
    chk("R5 wr_sel_o", 32'(wr_sel_o), 32'(e_wr));
    @(posedge clk);
    for (int f = 0; f < NF; f++) begin
      if (gw[f]) m_dst[f] = '0;
      if (gr[f]) m_src[f] = '0;
      if (iss[f]) begin
        m_dst[f] = m_dst[f] | d;
        m_src[f] = m_src[f] | s1 | s2;
      end
    end
  endtask

  task automatic t_reset();
    cyc('0, 8'hff, 8'hff, 8'hff, 4'hf, 4'hf);
    chk("R1 rd_sel after reset", 32'(rd_sel_o), 32'h0);
    chk("R1 raw after reset", 32'(raw_o), 32'h0);
  endtask

  task automatic t_raw();
    cyc(4'b0001, 8'h08, '0, '0, '0, '0);      // R2: unit0 reserves dest r3
    cyc('0, '0, 8'h08, '0, '0, '0);
    chk("R3 raw via src1", 32'(raw_o), 32'b1110);
    chk("R9 own row raw", 32'(raw_o[0]), 32'h0);
    cyc('0, '0, '0, 8'h08, '0, '0);
    chk("R3 raw via src2", 32'(raw_o), 32'b1110);
  endtask

  task automatic t_war();
    cyc(4'b0100, '0, 8'h20, 8'h40, '0, '0);   // unit2 sources r5, r6
    cyc('0, 8'h40, '0, '0, '0, '0);
    chk("R4 war on r6", 32'(war_o), 32'b1011);
    chk("R9 own row war", 32'(war_o[2]), 32'h0);
  endtask

  task automatic t_select();
    cyc('0, '0, '0, '0, 4'b0100, '0);
    chk("R5 read select r5 r6", 32'(rd_sel_o), 32'h60);
    cyc('0, '0, '0, '0, 4'b0100, '0);
    chk("R7 read select one cycle", 32'(rd_sel_o), 32'h0);
    cyc('0, 8'h40, '0, '0, '0, '0);
    chk("R7 war gone after read", 32'(war_o), 32'h0);
    cyc('0, '0, '0, '0, '0, 4'b0001);
    chk("R5 write select r3", 32'(wr_sel_o), 32'h08);
    cyc('0, '0, '0, '0, '0, 4'b0001);
    chk("R7 write select one cycle", 32'(wr_sel_o), 32'h0);
    cyc('0, '0, 8'h08, '0, '0, '0);
    chk("R7 raw gone after write", 32'(raw_o), 32'h0);
  endtask

  task automatic t_column();
    cyc(4'b0001, '0, 8'h02, '0, '0, '0);
    cyc(4'b0010, '0, '0, 8'h02, '0, '0);
    cyc('0, '0, '0, '0, 4'b0001, '0);
    chk("R6 column r1 from unit0", 32'(rd_sel_o), 32'h02);
    cyc('0, '0, '0, '0, 4'b0010, '0);
    chk("R6 column r1 still held by unit1", 32'(rd_sel_o), 32'h02);
    cyc('0, '0, '0, '0, 4'b0010, '0);
    chk("R6 column r1 empty", 32'(rd_sel_o), 32'h0);
  endtask

  task automatic t_collision();
    cyc(4'b1000, 8'h80, '0, '0, '0, 4'b1000);
    chk("R8 no write select before set", 32'(wr_sel_o), 32'h0);
    cyc('0, '0, '0, '0, '0, 4'b1000);
    chk("R8 set kept over clear (dest)", 32'(wr_sel_o), 32'h80);
    cyc(4'b1000, '0, 8'h01, '0, '0, '0);
    cyc(4'b1000, '0, 8'h04, '0, 4'b1000, '0);
    chk("R8 old source selected", 32'(rd_sel_o), 32'h01);
    cyc('0, '0, '0, '0, 4'b1000, '0);
    chk("R8 new source kept, old released", 32'(rd_sel_o), 32'h04);
    cyc('0, '0, '0, '0, 4'b1000, 4'b1000);
    chk("R7 all released", 32'(rd_sel_o | wr_sel_o), 32'h0);
  endtask

  initial begin
    model_clear();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_raw();
    t_war();
    t_select();
    t_column();
    t_collision();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule